// File: doc/BRIEF.md
# Six-Channel Driver Serial Register Bank

A serial control bank for a six-channel low-side gate pre-driver. A host writes nine-bit frames over a four-wire serial link: a three-bit address followed by six data bits, most significant bit first. The frame is acted on only when chip select returns high, and only if exactly nine clock edges were seen. The bank holds three programmable registers. A configuration register picks the fault reference level and the refresh period for each half of the channels. A mask register gates each channel's drain feedback into the flags. A gate-select register holds the serial gate commands.

Every frame shifts the six latched per-channel fault bits back to the host, whatever the address. An address with its top bit set is a pure readback that writes nothing. A fault latch clears at the end of a valid frame unless its channel still reports a fault. A global fault flag is re-evaluated on each valid frame end. A status flag follows the masked live feedback. Mask changes reach the two flags with different lags. All serial and feedback inputs are asynchronous and pass through synchronizers inside the block.

Top module: `drvbank`

## Requirements
- R1: A frame is acted on only when chip select rises after exactly 9 serial-clock rising edges. Bits arrive MSB first as A2 A1 A0 D5..D0. A frame with any other edge count changes no register, no flag and no fault latch.
- R2: Address 010 writes the configuration register. For channels 5..3 (`ref_sel_o[2c+1:2c]`), D4:D3 give the reference code and D5 gives `refr_sel_o[1]`. For channels 2..0, D1:D0 give the code and D2 gives `refr_sel_o[0]`. Codes 00/01/10/11 mean 25/50/75/100 % of full scale. A refresh bit of 0 means 10 ms and 1 means 40 ms. Reset value is 0.
- R3: Address 011 writes the mask, where Dc belongs to channel c. A 1 enables channel c's feedback into both flags and a 0 masks it. The mask resets to all zeros.
- R4: Address 001 writes D5..D0 to `gate_sel_o[5:0]`. Reset value is 0.
- R5: Any address with A2=1 (null access), and address 000, change no register.
- R6: While chip select is low, `sdo_o` presents the fault latches bit 5 first, one bit per serial-clock falling edge, then zeros. `sdo_oe_o` is 1 only while chip select is low.
- R7: A fault latch sets while its channel's drain feedback is high and holds that value. At the end of a valid frame it takes the current feedback value.
- R8: At each valid frame end, `fault_flag_o` becomes the OR over channels of latch & (old mask | new mask). The flag holds between valid frames. A mask bit going 1→0 therefore leaves the flag after two frames, and a mask bit going 0→1 reaches it after one frame.
- R9: `status_flag_o` is the OR over channels of live feedback & current mask, so a mask write reaches it after one frame.
- R10: After reset, all outputs are 0 and both flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock |
| cs_ni | input | 1 | Chip select, active low |
| sdi_i | input | 1 | Serial data in |
| drain_i | input | 6 | Per-channel drain fault feedback |
| sdo_o | output | 1 | Serial data out |
| sdo_oe_o | output | 1 | Serial output enable (0 = high impedance) |
| ref_sel_o | output | 12 | Fault reference code, 2 bits per channel |
| refr_sel_o | output | 2 | Refresh period select, bit 1 for channels 5..3 |
| gate_sel_o | output | 6 | Serial gate-select bits |
| fault_flag_o | output | 1 | Global fault flag |
| status_flag_o | output | 1 | Status flag |

## Verification
The fault-latch clear and the fault-flag update happen on the same frame-end edge. That edge can also carry a mask write. The bench provokes this by latching a fault, removing the feedback, and then sending readback and mask-write frames. The flag must be computed from the latch value before the clear, using the old and new masks together, while the latch reloads from live feedback. The expected result comes from a frame-level model that is compared on every settled clock and at each serial bit.

// File: rtl/drvbank_pkg.sv
package drvbank_pkg;
  localparam int NCH       = 6;
  localparam int ADDR_W    = 3;
  localparam int DATA_W    = 6;
  localparam int FRAME_W   = ADDR_W + DATA_W;
  localparam int CNT_W     = $clog2(FRAME_W) + 1;
  localparam int SYNC_STG  = 2;
  localparam logic [ADDR_W-1:0] ADDR_GATE = 3'b001;
  localparam logic [ADDR_W-1:0] ADDR_CFG  = 3'b010;
  localparam logic [ADDR_W-1:0] ADDR_MASK = 3'b011;
  typedef enum logic [1:0] {REF_25, REF_50, REF_75, REF_FULL} ref_level_e;
endpackage

// File: rtl/drvbank_sync.sv
module drvbank_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= RST_VAL;
    end else begin
      stage_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/drvbank_spi.sv
module drvbank_spi
  import drvbank_pkg::*;
#(
  parameter int FW = FRAME_W,
  parameter int DW = DATA_W,
  parameter int CW = CNT_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sclk_s_i,
  input  logic          cs_s_i,
  input  logic          sdi_s_i,
  input  logic [DW-1:0] load_i,
  output logic          cs_rise_o,
  output logic          frame_ok_o,
  output logic [FW-1:0] rx_o,
  output logic          sdo_o,
  output logic          sdo_oe_o
);
  localparam logic [CW-1:0] CNT_MAX = '1;
  localparam logic [CW-1:0] CNT_FRM = CW'(FW);

  logic cs_d, sclk_d;
  logic cs_fall, sclk_rise, sclk_fall;
  logic [CW-1:0] cnt_q;
  logic [FW-1:0] rx_q, tx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_d   <= 1'b1;
      sclk_d <= 1'b0;
    end else begin
      cs_d   <= cs_s_i;
      sclk_d <= sclk_s_i;
    end
  end

  assign cs_fall   = cs_d & ~cs_s_i;
  assign cs_rise_o = ~cs_d & cs_s_i;
  assign sclk_rise = ~sclk_d & sclk_s_i & ~cs_s_i;
  assign sclk_fall = sclk_d & ~sclk_s_i & ~cs_s_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      rx_q  <= '0;
      tx_q  <= '0;
    end else if (cs_fall) begin
      cnt_q <= '0;
      tx_q  <= {load_i, {(FW-DW){1'b0}}};
    end else begin
      if (sclk_rise) begin
        rx_q <= {rx_q[FW-2:0], sdi_s_i};
        if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
      end
      if (sclk_fall) tx_q <= {tx_q[FW-2:0], 1'b0};
    end
  end

  assign frame_ok_o = cs_rise_o && (cnt_q == CNT_FRM);
  assign rx_o       = rx_q;
  assign sdo_o      = tx_q[FW-1];
  assign sdo_oe_o   = ~cs_s_i;
endmodule

// File: rtl/drvbank_regs.sv
module drvbank_regs
  import drvbank_pkg::*;
#(
  parameter int FW = FRAME_W,
  parameter int DW = DATA_W,
  parameter int AW = ADDR_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [FW-1:0] frame_i,
  output logic [DW-1:0] mask_o,
  output logic [DW-1:0] mask_nxt_o,
  output logic [DW-1:0] gate_o,
  output logic [DW-1:0] cfg_o
);
  logic [AW-1:0] addr;
  logic [DW-1:0] data;
  logic hit_gate, hit_cfg, hit_mask;

  assign addr     = frame_i[FW-1 -: AW];
  assign data     = frame_i[DW-1:0];
  assign hit_gate = wr_i && addr == ADDR_GATE;
  assign hit_cfg  = wr_i && addr == ADDR_CFG;
  assign hit_mask = wr_i && addr == ADDR_MASK;

  assign mask_nxt_o = hit_mask ? data : mask_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_o <= '0;
      gate_o <= '0;
      cfg_o  <= '0;
    end else begin
      mask_o <= mask_nxt_o;
      if (hit_gate) gate_o <= data;
      if (hit_cfg)  cfg_o  <= data;
    end
  end
endmodule

// File: rtl/drvbank_fault.sv
module drvbank_fault
  import drvbank_pkg::*;
#(
  parameter int N = NCH
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         frame_ok_i,
  input  logic [N-1:0] drain_s_i,
  input  logic [N-1:0] mask_i,
  input  logic [N-1:0] mask_nxt_i,
  output logic [N-1:0] fault_o,
  output logic         fault_flag_o,
  output logic         status_flag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fault_o       <= '0;
      fault_flag_o  <= 1'b0;
      status_flag_o <= 1'b0;
    end else begin
      // old|new mask: set->clr shows now, clr->set one frame later
      if (frame_ok_i) begin
        fault_o      <= drain_s_i;
        fault_flag_o <= |(fault_o & (mask_i | mask_nxt_i));
      end else begin
        fault_o <= fault_o | drain_s_i;
      end
      status_flag_o <= |(drain_s_i & mask_i);
    end
  end
endmodule

// File: rtl/drvbank.sv
module drvbank
  import drvbank_pkg::*;
#(
  parameter int N  = NCH,
  parameter int SS = SYNC_STG
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           sclk_i,
  input  logic           cs_ni,
  input  logic           sdi_i,
  input  logic [N-1:0]   drain_i,
  output logic           sdo_o,
  output logic           sdo_oe_o,
  output logic [2*N-1:0] ref_sel_o,
  output logic [1:0]     refr_sel_o,
  output logic [N-1:0]   gate_sel_o,
  output logic           fault_flag_o,
  output logic           status_flag_o
);
  localparam int HALF = N / 2;
  localparam int GRP  = DATA_W / 2;

  logic [2:0] ctl_s;
  logic sclk_s, cs_s, sdi_s;
  logic [N-1:0] drain_s;
  logic cs_rise, frame_ok;
  logic [FRAME_W-1:0] rx_q;
  logic [DATA_W-1:0] mask_q, mask_nxt, gate_q, cfg_q;
  logic [N-1:0] fault_q;

  drvbank_sync #(.W(3), .STAGES(SS), .RST_VAL(3'b010)) u_sync_ctl (
    .clk_i, .rst_ni, .d_i({sclk_i, cs_ni, sdi_i}), .q_o(ctl_s));
  assign {sclk_s, cs_s, sdi_s} = ctl_s;

  drvbank_sync #(.W(N), .STAGES(SS), .RST_VAL('0)) u_sync_drn (
    .clk_i, .rst_ni, .d_i(drain_i), .q_o(drain_s));

  drvbank_spi u_spi (
    .clk_i, .rst_ni, .sclk_s_i(sclk_s), .cs_s_i(cs_s), .sdi_s_i(sdi_s),
    .load_i(fault_q), .cs_rise_o(cs_rise), .frame_ok_o(frame_ok),
    .rx_o(rx_q), .sdo_o, .sdo_oe_o);

  drvbank_regs u_regs (
    .clk_i, .rst_ni, .wr_i(frame_ok), .frame_i(rx_q),
    .mask_o(mask_q), .mask_nxt_o(mask_nxt), .gate_o(gate_q), .cfg_o(cfg_q));

  drvbank_fault #(.N(N)) u_fault (
    .clk_i, .rst_ni, .frame_ok_i(frame_ok), .drain_s_i(drain_s),
    .mask_i(mask_q), .mask_nxt_i(mask_nxt), .fault_o(fault_q),
    .fault_flag_o, .status_flag_o);

  for (genvar c = 0; c < N; c++) begin : g_ref
    if (c >= HALF) begin : g_hi
      assign ref_sel_o[2*c +: 2] = cfg_q[GRP +: 2];
    end else begin : g_lo
      assign ref_sel_o[2*c +: 2] = cfg_q[1:0];
    end
  end

  assign refr_sel_o = {cfg_q[2*GRP-1], cfg_q[GRP-1]};
  assign gate_sel_o = gate_q;
endmodule

// File: rtl/drvbank_chk.sv
module drvbank_chk
  import drvbank_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               cs_rise,
  input logic               frame_ok,
  input logic [FRAME_W-1:0] rx_q,
  input logic [DATA_W-1:0]  mask_q,
  input logic [DATA_W-1:0]  gate_q,
  input logic [DATA_W-1:0]  cfg_q,
  input logic [NCH-1:0]     fault_q,
  input logic [NCH-1:0]     drain_s,
  input logic               fault_flag_o,
  input logic               status_flag_o
);
  AST_BAD_FRAME_DROPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_rise && !frame_ok) |=> ($stable(mask_q) && $stable(gate_q) && $stable(cfg_q) && $stable(fault_flag_o))); // R1
  AST_NULL_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_ok && rx_q[FRAME_W-1]) |=> ($stable(mask_q) && $stable(gate_q) && $stable(cfg_q))); // R5
  AST_MASK_LOADED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_ok && rx_q[FRAME_W-1 -: ADDR_W] == ADDR_MASK) |=> (mask_q == $past(rx_q[DATA_W-1:0]))); // R3
  AST_FLAG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_ok |=> $stable(fault_flag_o)); // R8
  AST_FAULT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_ok |=> ((fault_q & $past(fault_q)) == $past(fault_q))); // R7
  AST_STATUS_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((drain_s & mask_q) == '0) |=> !status_flag_o); // R9
endmodule

bind drvbank drvbank_chk u_chk (
  .clk_i, .rst_ni, .cs_rise, .frame_ok, .rx_q, .mask_q, .gate_q, .cfg_q,
  .fault_q, .drain_s, .fault_flag_o, .status_flag_o);

// File: tb/drvbank_test.sv
module drvbank_test;
  logic clk = 0;
  always #5 clk = ~clk;

  logic rst_ni, sclk, cs_n, sdi, sdo, sdo_oe, ff, sf;
  logic [5:0] drain, gate;
  logic [11:0] refs;
  logic [1:0] refr;

  drvbank uut (
    .clk_i(clk), .rst_ni, .sclk_i(sclk), .cs_ni(cs_n), .sdi_i(sdi), .drain_i(drain),
    .sdo_o(sdo), .sdo_oe_o(sdo_oe), .ref_sel_o(refs), .refr_sel_o(refr),
    .gate_sel_o(gate), .fault_flag_o(ff), .status_flag_o(sf));

  integer errs = 0, checks = 0, cyc = 0, chg = 0;
  bit done = 0;
  logic [5:0] m_mask = 0, m_gate = 0, m_cfg = 0, m_flt = 0, m_drain = 0;
  logic m_ff = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  function automatic logic [11:0] exp_ref(input logic [5:0] c);
    logic [11:0] r;
    for (int k = 0; k < 6; k++) r[2*k +: 2] = (k >= 3) ? c[4:3] : c[1:0];
    return r;
  endfunction

  always @(posedge clk) cyc++;

  // per-clock model comparison once inputs have settled
  always @(negedge clk) begin
    if (rst_ni && !done && (cyc - chg) >= 6) begin
      chk(refs == exp_ref(m_cfg), "R2 ref_sel", refs, exp_ref(m_cfg));
      chk(refr == {m_cfg[5], m_cfg[2]}, "R2 refr_sel", refr, {m_cfg[5], m_cfg[2]});
      chk(gate == m_gate, "R4 gate_sel", gate, m_gate);
      chk(ff == m_ff, "R8 fault_flag", ff, m_ff);
      chk(sf == |(m_drain & m_mask), "R9 status_flag", sf, |(m_drain & m_mask));
      chk(sdo_oe == !cs_n, "R6 sdo_oe", sdo_oe, !cs_n);
    end
  end

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_drain(input logic [5:0] v);
    chg = cyc; drain = v; m_drain = v; m_flt = m_flt | v;
    wclk(8);
  endtask

  task automatic frame(input logic [8:0] w, input int n);
    logic [8:0] snap;
    logic [5:0] nm;
    snap = {m_flt, 3'b000};
    chg = cyc; cs_n = 0; wclk(6);
    for (int i = 0; i < n; i++) begin
      chg = cyc; sdi = (i < 9) ? w[8-i] : 1'b0; wclk(6);
      if (i < 9) chk(sdo == snap[8-i], "R6 sdo bit", sdo, snap[8-i]);
      chg = cyc; sclk = 1; wclk(6);
      chg = cyc; sclk = 0; wclk(6);
    end
    chg = cyc; cs_n = 1;
    if (n == 9) begin
      nm = (w[8:6] == 3'b011) ? w[5:0] : m_mask;
      m_ff = |(m_flt & (m_mask | nm));
      m_flt = m_drain;
      if (w[8:6] == 3'b001) m_gate = w[5:0];
      if (w[8:6] == 3'b010) m_cfg = w[5:0];
      m_mask = nm;
    end
    wclk(10);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1; errs++; checks++;
      $display("FAIL R1 watchdog expired: actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    rst_ni = 0; cs_n = 1; sclk = 0; sdi = 0; drain = 0;
    wclk(4); rst_ni = 1; chg = cyc; wclk(8);
    // R10 reset state
    chk(refs == 0 && refr == 0 && gate == 0, "R10 regs after reset", {refs, refr, gate}, 0);
    chk(ff == 0 && sf == 0 && sdo_oe == 0, "R10 flags after reset", {ff, sf, sdo_oe}, 0);

    frame({3'b010, 6'b101011}, 9);             // R2
    chk(refs[11:10] == 2'b01 && refs[1:0] == 2'b11 && refr == 2'b10, "R2 cfg decode", {refs, refr}, {12'b010101111111, 2'b10});
    frame({3'b001, 6'b100101}, 9);             // R4
    chk(gate == 6'b100101, "R4 gate write", gate, 6'b100101);
    frame({3'b111, 6'b111111}, 9);             // R5 null
    frame({3'b100, 6'b010101}, 9);             // R5 null
    frame({3'b000, 6'b111111}, 9);             // R5 unused address
    chk(gate == 6'b100101 && refr == 2'b10, "R5 null leaves regs", {gate, refr}, {6'b100101, 2'b10});
    frame({3'b001, 6'b011010}, 8);             // R1 short
    frame({3'b001, 6'b011010}, 10);            // R1 long
    chk(gate == 6'b100101, "R1 bad-length frame dropped", gate, 6'b100101);

    // R3: masked channel does not reach flags
    set_drain(6'b000100);
    chk(sf == 0, "R3 masked status", sf, 0);
    frame({3'b100, 6'b0}, 9);                  // R6 reads fault bit 2, R7 stays
    chk(ff == 0, "R3 masked fault flag", ff, 0);
    // R8 set->clr reaches fault flag after one frame
    frame({3'b011, 6'b000100}, 9);
    chk(ff == 1, "R8 unmask one frame", ff, 1);
    chk(sf == 1, "R9 status after unmask", sf, 1);
    // R7 latch holds after feedback drops, clears after readback
    set_drain(6'b0);
    chk(sf == 0, "R9 live feedback low", sf, 0);
    frame({3'b100, 6'b0}, 9);                  // snap shows bit 2
    chk(ff == 1, "R8 flag from pre-clear latch", ff, 1);
    frame({3'b100, 6'b0}, 9);                  // snap shows 0
    chk(ff == 0, "R7 latch cleared", ff, 0);
    // R7 invalid frame does not clear latch
    set_drain(6'b010000); set_drain(6'b0);
    frame({3'b100, 6'b0}, 5);
    frame({3'b100, 6'b0}, 9);                  // sdo must still show bit 4
    // R8 clr->set: two frames
    set_drain(6'b000100);
    frame({3'b100, 6'b0}, 9);
    chk(ff == 1, "R8 fault present", ff, 1);
    frame({3'b011, 6'b000000}, 9);
    chk(ff == 1, "R8 mask set, first frame keeps flag", ff, 1);
    chk(sf == 0, "R9 mask set after one frame", sf, 0);
    frame({3'b100, 6'b0}, 9);
    chk(ff == 0, "R8 mask set, second frame drops flag", ff, 0);
    // mixed mask and drain patterns
    frame({3'b011, 6'b101010}, 9);
    set_drain(6'b010101);
    chk(sf == 0, "R9 disjoint mask", sf, 0);
    set_drain(6'b100001);
    chk(sf == 1, "R9 overlapping mask", sf, 1);
    frame({3'b110, 6'b0}, 9);
    frame({3'b010, 6'b010100}, 9);
    chk(refs[1:0] == 2'b00 && refs[7:6] == 2'b10 && refr == 2'b01, "R2 second cfg", {refs[7:6], refs[1:0], refr}, 6'b100001);

    wclk(10);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule